// File: doc/BRIEF.md
# Indirect-Access Interrupt Redirection Table

This block is the register file of an I/O interrupt controller that software reaches through only two locations: a select register and a data window. Software first writes the index of the internal register it wants into the select location, then reads or writes that 32-bit register through the window. Behind the window sit a unit identifier register, a read-only version register and a table of redirection entries, one per interrupt input line.

Each redirection entry is 64 bits wide and takes two adjacent indices. The low half, at the even index, carries the vector and the mask bit. The high half, at the odd index, carries the destination. After reset every entry is masked. Each line also drives two outputs straight from its entry: a mask flag and an 8-bit vector. Downstream routing logic uses these outputs; message delivery is not part of this block.

Reads return data in the same cycle the access is presented. Writes take effect at the next rising clock edge.

Top module: `irq_redir_window`

## Requirements
- R1: A write at byte offset 0x00 latches `acc_wdata[7:0]` as the select index. A read at offset 0x00 returns the select index zero-extended to 32 bits.
- R2: An access at byte offset 0x10 reaches the register named by the select index held at that moment. Read data appears combinationally in the same cycle. A write is visible from the next cycle on.
- R3: Index 0x00 is the unit ID register. Bits [31:24] are writable and all other bits read zero.
- R4: Index 0x01 is read-only and returns the highest entry number (entry count minus one, 0x17 by default) in bits [23:16] and the version code 0x20 in bits [7:0], with all other bits zero. Writes to it change nothing.
- R5: Entry n has its low half at index 0x10+2n and its high half at index 0x11+2n, for n from 0 to 23.
- R6: The low half stores bits [16:0], where bit 16 is the mask and bits [7:0] are the vector. Bits [31:17] read zero.
- R7: The high half stores only the destination in bits [31:24]. Its other bits read zero.
- R8: After reset the select index and the ID are zero. Every entry reads 0x00010000 in its low half and 0 in its high half.
- R9: At unimplemented indices (0x02 to 0x0F and 0x40 to 0xFF), window reads return zero and window writes change no state.
- R10: At byte offsets other than 0x00 and 0x10, reads return zero and writes change no state.
- R11: `line_masked[n]` equals bit 16 of entry n's low half and `line_vector[8n+7:8n]` equals its bits [7:0]. Both follow a write from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| acc_wr | input | 1 | Write strobe for the current access |
| acc_addr | input | 5 | Byte offset of the access |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data for the current offset |
| line_masked | output | 24 | Per-line mask flag |
| line_vector | output | 192 | Per-line vector, 8 bits per line |

## Verification
A corrupted select index misdirects the very next window access. That shows at once as wrong read data, or as a write landing on a neighbouring entry and surfacing on `line_masked` or `line_vector` one cycle later. A wrong half decode or a wrong entry offset shows as a mismatch between read-back data and the per-line outputs. Comparing both against an independent model on every cycle catches such faults within one access.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

    localparam int DATA_W = 32;
    localparam int SEL_W  = 8;
    localparam int ADDR_W = 5;

    typedef logic [SEL_W-1:0]  sel_t;
    typedef logic [ADDR_W-1:0] ofs_t;
    typedef logic [DATA_W-1:0] word_t;

    localparam ofs_t OFS_SEL = 5'h00;
    localparam ofs_t OFS_WIN = 5'h10;

    localparam sel_t IDX_ID   = 8'h00;
    localparam sel_t IDX_VER  = 8'h01;
    localparam sel_t IDX_BASE = 8'h10;

    typedef enum logic [1:0] {
        REG_NONE,
        REG_ID,
        REG_VER,
        REG_ENT
    } reg_kind_e;

    // low half of a redirection entry, bits [16:0] of the word
    typedef struct packed {
        logic       masked;
        logic       level_trig;
        logic       rsvd_14;
        logic       active_low;
        logic       rsvd_12;
        logic       logical_dst;
        logic [2:0] dlv_mode;
        logic [7:0] vector;
    } ent_lo_t;

    // high half: only the destination byte
    typedef struct packed {
        logic [7:0] dest;
    } ent_hi_t;

    localparam ent_lo_t LO_RESET = ent_lo_t'(17'h10000);
    localparam ent_hi_t HI_RESET = ent_hi_t'(8'h00);

    function automatic word_t lo_to_word(ent_lo_t e);
        return {15'd0, e};
    endfunction

    function automatic word_t hi_to_word(ent_hi_t e);
        return {e.dest, 24'd0};
    endfunction

    function automatic ent_lo_t word_to_lo(word_t w);
        return ent_lo_t'(w[16:0]);
    endfunction

    function automatic ent_hi_t word_to_hi(word_t w);
        return ent_hi_t'(w[31:24]);
    endfunction

endpackage

// File: rtl/irq_redir_decode.sv
module irq_redir_decode
    import irq_redir_pkg::*;
#(
    parameter int N_LINES = 24,
    parameter int ENT_W   = $clog2(N_LINES)
) (
    input  sel_t             sel,
    output reg_kind_e        kind,
    output logic [ENT_W-1:0] ent,
    output logic             hi_half
);
    localparam logic [SEL_W:0] TBL_END = (SEL_W+1)'(int'(IDX_BASE) + 2 * N_LINES);

    sel_t off;

    always_comb begin
        off     = sel - IDX_BASE;
        ent     = off[ENT_W:1];
        hi_half = off[0];
        if (sel == IDX_ID)
            kind = REG_ID;
        else if (sel == IDX_VER)
            kind = REG_VER;
        else if (sel >= IDX_BASE && {1'b0, sel} < TBL_END)
            kind = REG_ENT;
        else
            kind = REG_NONE;
    end

endmodule

// File: rtl/irq_redir_table.sv
module irq_redir_table
    import irq_redir_pkg::*;
#(
    parameter int N_LINES = 24,
    parameter int ENT_W   = $clog2(N_LINES)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_lo,
    input  logic                 wr_hi,
    input  logic [ENT_W-1:0]     ent,
    input  word_t                wdata,
    output ent_lo_t              rd_lo,
    output ent_hi_t              rd_hi,
    output logic [N_LINES-1:0]   line_masked,
    output logic [8*N_LINES-1:0] line_vector
);
    ent_lo_t lo_q [N_LINES];
    ent_hi_t hi_q [N_LINES];

    for (genvar n = 0; n < N_LINES; n++) begin : g_line
        always_ff @(posedge clk) begin
            if (rst) begin
                lo_q[n] <= LO_RESET;
                hi_q[n] <= HI_RESET;
            end else if (ent == ENT_W'(n)) begin
                if (wr_lo) lo_q[n] <= word_to_lo(wdata);
                if (wr_hi) hi_q[n] <= word_to_hi(wdata);
            end
        end
        assign line_masked[n]         = lo_q[n].masked;
        assign line_vector[8*n +: 8]  = lo_q[n].vector;
    end

    always_comb begin
        rd_lo = '0;
        rd_hi = '0;
        for (int n = 0; n < N_LINES; n++) begin
            if (ent == ENT_W'(n)) begin
                rd_lo = lo_q[n];
                rd_hi = hi_q[n];
            end
        end
    end

endmodule

// File: rtl/irq_redir_window.sv
module irq_redir_window
    import irq_redir_pkg::*;
#(
    parameter int         N_LINES  = 24,
    parameter logic [7:0] VER_CODE = 8'h20
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 acc_wr,
    input  logic [4:0]           acc_addr,
    input  logic [31:0]          acc_wdata,
    output logic [31:0]          acc_rdata,
    output logic [N_LINES-1:0]   line_masked,
    output logic [8*N_LINES-1:0] line_vector
);
    localparam int   ENT_W   = $clog2(N_LINES);
    localparam word_t VER_WORD = {8'd0, 8'(N_LINES - 1), 8'd0, VER_CODE};

    sel_t             sel_q;
    logic [7:0]       id_q;
    reg_kind_e        kind;
    logic [ENT_W-1:0] ent;
    logic             hi_half;
    ent_lo_t          rd_lo;
    ent_hi_t          rd_hi;
    logic             win_wr;

    irq_redir_decode #(.N_LINES(N_LINES), .ENT_W(ENT_W)) dec_i (
        .sel     (sel_q),
        .kind    (kind),
        .ent     (ent),
        .hi_half (hi_half)
    );

    assign win_wr = acc_wr && (acc_addr == OFS_WIN);

    irq_redir_table #(.N_LINES(N_LINES), .ENT_W(ENT_W)) tbl_i (
        .clk         (clk),
        .rst         (rst),
        .wr_lo       (win_wr && kind == REG_ENT && !hi_half),
        .wr_hi       (win_wr && kind == REG_ENT && hi_half),
        .ent         (ent),
        .wdata       (acc_wdata),
        .rd_lo       (rd_lo),
        .rd_hi       (rd_hi),
        .line_masked (line_masked),
        .line_vector (line_vector)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            sel_q <= '0;
            id_q  <= '0;
        end else begin
            if (acc_wr && acc_addr == OFS_SEL)
                sel_q <= acc_wdata[SEL_W-1:0];
            if (win_wr && kind == REG_ID)
                id_q <= acc_wdata[31:24];
        end
    end

    always_comb begin
        acc_rdata = '0;
        if (acc_addr == OFS_SEL) begin
            acc_rdata = {{(DATA_W-SEL_W){1'b0}}, sel_q};
        end else if (acc_addr == OFS_WIN) begin
            unique case (kind)
                REG_ID:   acc_rdata = {id_q, 24'd0};
                REG_VER:  acc_rdata = VER_WORD;
                REG_ENT:  acc_rdata = hi_half ? hi_to_word(rd_hi) : lo_to_word(rd_lo);
                default:  acc_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/irq_redir_window_chk.sv
module irq_redir_window_chk
    import irq_redir_pkg::*;
#(
    parameter int         N_LINES  = 24,
    parameter logic [7:0] VER_CODE = 8'h20
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 acc_wr,
    input logic [4:0]           acc_addr,
    input logic [31:0]          acc_wdata,
    input logic [31:0]          acc_rdata,
    input logic [7:0]           sel_q,
    input logic [N_LINES-1:0]   line_masked,
    input logic [8*N_LINES-1:0] line_vector
);
    localparam logic [SEL_W:0] TBL_END = (SEL_W+1)'(int'(IDX_BASE) + 2 * N_LINES);

    logic beyond_tbl;
    assign beyond_tbl = {1'b0, sel_q} >= TBL_END;

    // R8
    reset_masked_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (&line_masked && line_vector == '0));

    // R1
    sel_latch_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_addr == OFS_SEL) |=> sel_q == $past(acc_wdata[7:0]));

    // R10
    other_ofs_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_addr != OFS_SEL && acc_addr != OFS_WIN) |-> acc_rdata == '0);

    // R4
    ver_read_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_addr == OFS_WIN && sel_q == IDX_VER) |->
            acc_rdata == {8'd0, 8'(N_LINES - 1), 8'd0, VER_CODE});

    // R9
    unimpl_read_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_addr == OFS_WIN && beyond_tbl) |-> acc_rdata == '0);

    // R9
    unimpl_write_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_addr == OFS_WIN && beyond_tbl) |=>
            ($stable(line_masked) && $stable(line_vector)));

    // R6
    lo_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_addr == OFS_WIN && sel_q >= IDX_BASE && !beyond_tbl && !sel_q[0]) |->
            acc_rdata[31:17] == '0);

    // R10
    other_ofs_write_chk: assert property (@(posedge clk) disable iff (rst)
        (acc_wr && acc_addr != OFS_SEL && acc_addr != OFS_WIN) |=>
            ($stable(line_masked) && $stable(line_vector) && $stable(sel_q)));

endmodule

bind irq_redir_window irq_redir_window_chk #(.N_LINES(N_LINES), .VER_CODE(VER_CODE)) chk_i (
    .clk         (clk),
    .rst         (rst),
    .acc_wr      (acc_wr),
    .acc_addr    (acc_addr),
    .acc_wdata   (acc_wdata),
    .acc_rdata   (acc_rdata),
    .sel_q       (sel_q),
    .line_masked (line_masked),
    .line_vector (line_vector)
);

// File: tb/irq_redir_window_tb.sv
module irq_redir_window_tb_top;

    localparam int CLK_P = 10;
    localparam int NL    = 24;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            acc_wr = 1'b0;
    logic [4:0]      acc_addr = '0;
    logic [31:0]     acc_wdata = '0;
    logic [31:0]     acc_rdata;
    logic [NL-1:0]   line_masked;
    logic [8*NL-1:0] line_vector;

    int n_vec = 0;
    int n_bad = 0;

    // behavioural reference state
    logic [16:0] m_lo [NL];
    logic [7:0]  m_hi [NL];
    logic [7:0]  m_id;
    logic [7:0]  m_sel;

    always #(CLK_P/2) clk = ~clk;

    irq_redir_window #(.N_LINES(NL)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .acc_wr      (acc_wr),
        .acc_addr    (acc_addr),
        .acc_wdata   (acc_wdata),
        .acc_rdata   (acc_rdata),
        .line_masked (line_masked),
        .line_vector (line_vector)
    );

    function automatic logic [31:0] model_read(logic [4:0] a);
        int s;
        s = int'(m_sel);
        if (a == 5'h00) return {24'd0, m_sel};
        if (a != 5'h10) return 32'd0;
        if (s == 0) return {m_id, 24'd0};
        if (s == 1) return {8'd0, 8'd23, 8'd0, 8'h20};
        if (s >= 16 && s < 16 + 2*NL) begin
            if (s % 2 == 1) return {m_hi[(s-16)/2], 24'd0};
            return {15'd0, m_lo[(s-16)/2]};
        end
        return 32'd0;
    endfunction

    task automatic model_write(logic [4:0] a, logic [31:0] d);
        int s;
        s = int'(m_sel);
        if (a == 5'h00) m_sel = d[7:0];
        else if (a == 5'h10) begin
            if (s == 0) m_id = d[31:24];
            else if (s >= 16 && s < 16 + 2*NL) begin
                if (s % 2 == 1) m_hi[(s-16)/2] = d[31:24];
                else            m_lo[(s-16)/2] = d[16:0];
            end
        end
    endtask

    function automatic logic [255:0] model_lines();
        logic [255:0] r;
        r = '0;
        for (int n = 0; n < NL; n++) begin
            r[8*NL + n] = m_lo[n][16];
            r[8*n +: 8] = m_lo[n][7:0];
        end
        return r;
    endfunction

    function automatic string tag_of(logic [4:0] a);
        int s;
        s = int'(m_sel);
        if (a == 5'h00) return "R1";
        if (a != 5'h10) return "R10";
        if (s == 0) return "R3";
        if (s == 1) return "R4";
        if (s >= 16 && s < 16 + 2*NL) return (s % 2 == 1) ? "R7" : "R6";
        return "R9";
    endfunction

    task automatic chk(string tag, logic [255:0] act, logic [255:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one access; checks read data and line outputs before the edge
    task automatic op(bit wr, logic [4:0] a, logic [31:0] d, string tag);
        @(negedge clk);
        acc_wr    = wr;
        acc_addr  = a;
        acc_wdata = d;
        #(CLK_P/4);
        chk(tag, {224'd0, acc_rdata}, {224'd0, model_read(a)});
        chk("R11", {64'd0, line_masked, line_vector}, model_lines());
        @(posedge clk);
        if (wr) model_write(a, d);
    endtask

    task automatic set_sel(logic [7:0] s);
        op(1'b1, 5'h00, {24'hABCDEF, s}, "R1");
    endtask

    initial begin
        for (int n = 0; n < NL; n++) begin
            m_lo[n] = 17'h10000;
            m_hi[n] = 8'h00;
        end
        m_id  = '0;
        m_sel = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R8: reset state of select, ID and every entry
        op(1'b0, 5'h00, 32'd0, "R8");
        op(1'b0, 5'h10, 32'd0, "R8");
        for (int i = 16; i < 16 + 2*NL; i++) begin
            set_sel(8'(i));
            op(1'b0, 5'h10, 32'd0, "R8");
        end

        // R3: ID writable in top byte only
        set_sel(8'h00);
        op(1'b1, 5'h10, 32'hFFFF_FFFF, "R3");
        op(1'b0, 5'h10, 32'd0, "R3");

        // R4: version read-only
        set_sel(8'h01);
        op(1'b1, 5'h10, 32'hFFFF_FFFF, "R4");
        op(1'b0, 5'h10, 32'd0, "R4");

        // R5 / R2: entry 5 low at 0x1A, high at 0x1B
        set_sel(8'h1A);
        op(1'b1, 5'h10, 32'h0000_0042, "R2");
        op(1'b0, 5'h10, 32'd0, "R5");
        set_sel(8'h1B);
        op(1'b1, 5'h10, 32'hFFFF_FFFF, "R7");
        op(1'b0, 5'h10, 32'd0, "R5");
        // R6: upper bits of low half dropped
        set_sel(8'h10);
        op(1'b1, 5'h10, 32'hFFFF_FFFF, "R6");
        op(1'b0, 5'h10, 32'd0, "R6");
        // last entry, low half
        set_sel(8'h3E);
        op(1'b1, 5'h10, 32'h0000_00C3, "R5");
        op(1'b0, 5'h10, 32'd0, "R11");

        // R9: unimplemented indices at both ends of the gap
        set_sel(8'h05);
        op(1'b1, 5'h10, 32'hFFFF_FFFF, "R9");
        op(1'b0, 5'h10, 32'd0, "R9");
        set_sel(8'h40);
        op(1'b1, 5'h10, 32'hFFFF_FFFF, "R9");
        op(1'b0, 5'h10, 32'd0, "R9");
        set_sel(8'h0F);
        op(1'b1, 5'h10, 32'h0000_0000, "R9");

        // R10: stray offsets
        op(1'b1, 5'h04, 32'hFFFF_FFFF, "R10");
        op(1'b0, 5'h04, 32'd0, "R10");
        op(1'b1, 5'h1F, 32'h0000_0000, "R10");
        op(1'b0, 5'h00, 32'd0, "R1");

        // mixed traffic
        for (int k = 0; k < 3000; k++) begin
            logic [4:0]  a;
            logic [31:0] d;
            int          pick;
            pick = int'($urandom_range(0, 9));
            if (pick < 3)      a = 5'h00;
            else if (pick < 9) a = 5'h10;
            else               a = 5'($urandom_range(0, 31));
            d = $urandom;
            if (a == 5'h00) d[7:0] = 8'($urandom_range(0, 71));
            op(($urandom_range(0, 1) == 1), a, d, tag_of(a));
        end

        @(negedge clk);
        acc_wr = 1'b0;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(CLK_P * 200000);
        n_bad++;
        $display("FAIL R2 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule